// File: doc/BRIEF.md
# Two-B-plus-D Serial Framer

This block carries two 8-bit bearer channels (B1, B2) and a 2-bit signalling channel (D) over a frame-synchronised serial bus, in both directions. On the transmit side it captures parallel B1, B2 and D words when a frame starts. It then shifts them out, most significant bit first, one bit per bit-clock period. On the receive side it samples the serial input, rebuilds the three words and presents them with a one-cycle valid strobe once the last active bit of a frame has been taken.

A layout input selects one of two fixed frame layouts. The *split* layout (layout input 0) packs the channels into the first 19 bit positions and places a single D bit after each B channel. The *block* layout (layout input 1) sends B1 then B2 back to back, leaves an 8-bit gap, and ends with both D bits, for 26 positions in all. Every position after the active region is ignored until the next frame sync. In master mode the block generates its own bit clock and a square-wave frame sync. In slave mode it follows a bit clock and sync supplied from outside. Everything runs from one system clock, and the bit clock is handled as a level whose edges are detected.

Top module: `bd_framer`

## Requirements
- R1: In the split layout, bit positions 0..18 carry B1[7..0], D[1], one ignored bit, B2[7..0], D[0], in that order. The serial output changes only after a rising bit-clock edge.
- R2: In the block layout, bit positions 0..25 carry B1[7..0], B2[7..0], eight ignored bits, D[1], D[0], in that order.
- R3: The serial output is 1 (idle) on ignored bits inside the active region, on every position after it, and before the first frame sync.
- R4: In the split layout, receive data sampled on falling bit-clock edges at positions 0..7, 8, 10..17 and 18 rebuild B1, D[1], B2 and D[0]. The value at position 9 has no effect.
- R5: In the block layout, receive positions 0..7, 8..15, 24 and 25 rebuild B1, B2, D[1] and D[0]. Positions 16..23 and everything after position 25 have no effect.
- R6: The receive valid output pulses for exactly one system clock, once per complete frame, right after the last active bit (position 18 or 25) is sampled. The receive words change only with that pulse.
- R7: A frame sync is a low-to-high change of the sync level seen on falling bit-clock edges, and the next rising edge becomes position 0. A sync that arrives before the active region ends restarts the count at 0, raises no valid pulse and leaves the receive words unchanged.
- R8: The transmit words and the layout are captured at the rising edge that starts position 0. Changing them later in the frame has no effect on that frame, in either direction.
- R9: In master mode, the bit-clock output has a period of 2*CLK_DIV system clocks. The sync output is a square wave, high for FRAME_BITS/2 bit periods in each frame of FRAME_BITS bit periods.
- R10: In master mode, with the serial output looped back to the serial input, the receive words equal the transmit words, in both layouts.
- R11: In slave mode, the bit-clock and sync outputs stay low.
- R12: After reset the serial output is 1, the valid output is 0 and all receive words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 selects master mode (internal bit clock and sync), 0 selects slave mode |
| layout_i | input | 1 | 0 selects the split layout, 1 selects the block layout |
| bclk_i | input | 1 | External bit-clock level (slave mode) |
| fsync_i | input | 1 | External frame-sync level (slave mode) |
| bclk_o | output | 1 | Generated bit-clock level (master mode) |
| fsync_o | output | 1 | Generated square-wave frame sync (master mode) |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| tx_b1_i | input | 8 | Transmit B1 word |
| tx_b2_i | input | 8 | Transmit B2 word |
| tx_d_i | input | 2 | Transmit D bits |
| rx_b1_o | output | 8 | Received B1 word |
| rx_b2_o | output | 8 | Received B2 word |
| rx_d_o | output | 2 | Received D bits |
| rx_valid_o | output | 1 | One-cycle strobe when a frame's receive words are updated |

## Verification
Slave-mode frames in both layouts carry distinct, asymmetric byte patterns: 0xA5/0x3C, 0x81/0x7E, all-zero against all-one, and single-bit words. These separate bit order from byte order and also show whether B1 and B2 are swapped. Receive frames fill the ignored positions with an alternating pattern, so that a decoder sampling a wrong position produces a visibly wrong word. A truncated frame followed by a full frame checks the restart and the discard. A frame whose inputs and layout flip at position 3 checks the capture at frame start. Master-mode runs loop the serial output back in each layout and time the generated bit clock and sync against their expected periods.

// File: rtl/bd_framer_pkg.sv
package bd_framer_pkg;

  localparam int unsigned B_W = 8;
  localparam int unsigned D_W = 2;

  typedef enum logic {
    LAY_SPLIT = 1'b0,
    LAY_BLOCK = 1'b1
  } layout_e;

  typedef enum logic [1:0] {
    SL_NONE = 2'd0,
    SL_B1   = 2'd1,
    SL_B2   = 2'd2,
    SL_D    = 2'd3
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic [2:0] idx;
  } slot_t;

  // Split layout positions
  localparam int unsigned SP_B1_START = 0;
  localparam int unsigned SP_D_HI     = 8;
  localparam int unsigned SP_B2_START = 10;
  localparam int unsigned SP_D_LO     = 18;
  // Block layout positions
  localparam int unsigned BK_B1_START = 0;
  localparam int unsigned BK_B2_START = 8;
  localparam int unsigned BK_D_HI     = 24;
  localparam int unsigned BK_D_LO     = 25;

  // Last active position of a layout
  function automatic int unsigned last_pos(layout_e lay);
    return (lay == LAY_SPLIT) ? SP_D_LO : BK_D_LO;
  endfunction

  // What a bit position carries, and which bit of the field
  function automatic slot_t slot_of(layout_e lay, int unsigned pos);
    slot_t s;
    s.kind = SL_NONE;
    s.idx  = 3'd0;
    if (lay == LAY_SPLIT) begin
      if (pos < SP_B1_START + B_W) begin
        s.kind = SL_B1;
        s.idx  = 3'(SP_B1_START + B_W - 1 - pos);
      end else if (pos == SP_D_HI) begin
        s.kind = SL_D;
        s.idx  = 3'd1;
      end else if (pos >= SP_B2_START && pos < SP_B2_START + B_W) begin
        s.kind = SL_B2;
        s.idx  = 3'(SP_B2_START + B_W - 1 - pos);
      end else if (pos == SP_D_LO) begin
        s.kind = SL_D;
        s.idx  = 3'd0;
      end
    end else begin
      if (pos < BK_B1_START + B_W) begin
        s.kind = SL_B1;
        s.idx  = 3'(BK_B1_START + B_W - 1 - pos);
      end else if (pos >= BK_B2_START && pos < BK_B2_START + B_W) begin
        s.kind = SL_B2;
        s.idx  = 3'(BK_B2_START + B_W - 1 - pos);
      end else if (pos == BK_D_HI) begin
        s.kind = SL_D;
        s.idx  = 3'd1;
      end else if (pos == BK_D_LO) begin
        s.kind = SL_D;
        s.idx  = 3'd0;
      end
    end
    return s;
  endfunction

  // Serial level for a slot; idle level 1 where nothing is carried
  function automatic logic tx_bit(slot_t s, logic [B_W-1:0] b1,
                                  logic [B_W-1:0] b2, logic [D_W-1:0] d);
    logic v;
    case (s.kind)
      SL_B1:   v = b1[s.idx];
      SL_B2:   v = b2[s.idx];
      SL_D:    v = d[s.idx[0]];
      default: v = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/bd_fr_clkgen.sv
module bd_fr_clkgen #(
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic bclk_o,
  output logic fsync_o
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] HALF     = CNT_W'(FRAME_BITS / 2);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] bit_q;
  logic [CNT_W-1:0] bit_nxt;

  assign bit_nxt = (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      bit_q   <= '0;
      bclk_o  <= 1'b0;
      fsync_o <= 1'b0;
    end else if (!en_i) begin
      div_q   <= '0;
      bit_q   <= '0;
      bclk_o  <= 1'b0;
      fsync_o <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q  <= '0;
      bclk_o <= ~bclk_o;
      if (!bclk_o) begin
        bit_q   <= bit_nxt;
        fsync_o <= (bit_nxt < HALF);
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/bd_fr_timing.sv
module bd_fr_timing #(
  parameter int unsigned FRAME_BITS = 64,
  parameter int unsigned POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_lvl_i,
  input  logic             fs_lvl_i,
  input  logic             lay_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             sync_o,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_n,
  output logic             lay_q,
  output logic             lay_n
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(FRAME_BITS - 1);

  logic lvl_q;
  logic fs_seen_q;
  logic pend_q;

  assign rise_o = bclk_lvl_i & ~lvl_q;
  assign fall_o = ~bclk_lvl_i & lvl_q;
  assign sync_o = rise_o & pend_q;

  // Saturating position: stays parked past the active region until a sync
  always_comb begin
    pos_n = pos_q;
    lay_n = lay_q;
    if (sync_o) begin
      pos_n = '0;
      lay_n = lay_i;
    end else if (rise_o && pos_q != POS_MAX) begin
      pos_n = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      fs_seen_q <= 1'b0;
      pend_q    <= 1'b0;
      pos_q     <= POS_MAX;
      lay_q     <= 1'b0;
    end else begin
      lvl_q <= bclk_lvl_i;
      pos_q <= pos_n;
      lay_q <= lay_n;
      if (fall_o) begin
        fs_seen_q <= fs_lvl_i;
        if (fs_lvl_i && !fs_seen_q) pend_q <= 1'b1;
      end else if (rise_o) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bd_fr_tx.sv
module bd_fr_tx
  import bd_framer_pkg::*;
#(
  parameter int unsigned POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             sync_i,
  input  logic [POS_W-1:0] pos_n_i,
  input  logic             lay_n_i,
  input  logic [B_W-1:0]   b1_i,
  input  logic [B_W-1:0]   b2_i,
  input  logic [D_W-1:0]   d_i,
  output logic             txd_o
);
  logic [B_W-1:0] b1_q, b2_q;
  logic [D_W-1:0] d_q;
  logic [B_W-1:0] b1_use, b2_use;
  logic [D_W-1:0] d_use;
  slot_t          slot_w;

  assign b1_use = sync_i ? b1_i : b1_q;
  assign b2_use = sync_i ? b2_i : b2_q;
  assign d_use  = sync_i ? d_i  : d_q;
  assign slot_w = slot_of(layout_e'(lay_n_i), int'(pos_n_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1_q  <= '0;
      b2_q  <= '0;
      d_q   <= '0;
      txd_o <= 1'b1;
    end else begin
      if (sync_i) begin
        b1_q <= b1_i;
        b2_q <= b2_i;
        d_q  <= d_i;
      end
      if (rise_i) txd_o <= tx_bit(slot_w, b1_use, b2_use, d_use);
    end
  end
endmodule

// File: rtl/bd_fr_rx.sv
module bd_fr_rx
  import bd_framer_pkg::*;
#(
  parameter int unsigned POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             lay_i,
  input  logic             rxd_i,
  output logic [B_W-1:0]   b1_o,
  output logic [B_W-1:0]   b2_o,
  output logic [D_W-1:0]   d_o,
  output logic             valid_o
);
  logic [B_W-1:0] acc_b1_q, acc_b2_q, nb1, nb2;
  logic [D_W-1:0] acc_d_q, nd;
  slot_t          slot_w;
  logic           last_w;

  assign slot_w = slot_of(layout_e'(lay_i), int'(pos_i));
  assign last_w = fall_i && (int'(pos_i) == last_pos(layout_e'(lay_i)));

  always_comb begin
    nb1 = acc_b1_q;
    nb2 = acc_b2_q;
    nd  = acc_d_q;
    if (fall_i) begin
      case (slot_w.kind)
        SL_B1:   nb1[slot_w.idx]    = rxd_i;
        SL_B2:   nb2[slot_w.idx]    = rxd_i;
        SL_D:    nd[slot_w.idx[0]]  = rxd_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_b1_q <= '0;
      acc_b2_q <= '0;
      acc_d_q  <= '0;
      b1_o     <= '0;
      b2_o     <= '0;
      d_o      <= '0;
      valid_o  <= 1'b0;
    end else begin
      acc_b1_q <= nb1;
      acc_b2_q <= nb2;
      acc_d_q  <= nd;
      valid_o  <= last_w;
      if (last_w) begin
        b1_o <= nb1;
        b2_o <= nb2;
        d_o  <= nd;
      end
    end
  end
endmodule

// File: rtl/bd_framer.sv
module bd_framer
  import bd_framer_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master_i,
  input  logic           layout_i,
  input  logic           bclk_i,
  input  logic           fsync_i,
  output logic           bclk_o,
  output logic           fsync_o,
  output logic           txd_o,
  input  logic           rxd_i,
  input  logic [B_W-1:0] tx_b1_i,
  input  logic [B_W-1:0] tx_b2_i,
  input  logic [D_W-1:0] tx_d_i,
  output logic [B_W-1:0] rx_b1_o,
  output logic [B_W-1:0] rx_b2_o,
  output logic [D_W-1:0] rx_d_o,
  output logic           rx_valid_o
);
  localparam int unsigned POS_W = $clog2(FRAME_BITS);

  // Named internal events, also observed by the checker
  logic             gen_bclk_w, gen_fs_w;
  logic             bclk_lvl_w, fs_lvl_w;
  logic             rise_w, fall_w, sync_w;
  logic [POS_W-1:0] pos_w, pos_nxt_w;
  logic             lay_w, lay_nxt_w;

  bd_fr_clkgen #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) u_gen (
    .clk(clk), .rst_n(rst_n), .en_i(master_i),
    .bclk_o(gen_bclk_w), .fsync_o(gen_fs_w)
  );

  assign bclk_o     = gen_bclk_w;
  assign fsync_o    = gen_fs_w;
  assign bclk_lvl_w = master_i ? gen_bclk_w : bclk_i;
  assign fs_lvl_w   = master_i ? gen_fs_w   : fsync_i;

  bd_fr_timing #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_tim (
    .clk(clk), .rst_n(rst_n),
    .bclk_lvl_i(bclk_lvl_w), .fs_lvl_i(fs_lvl_w), .lay_i(layout_i),
    .rise_o(rise_w), .fall_o(fall_w), .sync_o(sync_w),
    .pos_q(pos_w), .pos_n(pos_nxt_w), .lay_q(lay_w), .lay_n(lay_nxt_w)
  );

  bd_fr_tx #(.POS_W(POS_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w), .sync_i(sync_w),
    .pos_n_i(pos_nxt_w), .lay_n_i(lay_nxt_w),
    .b1_i(tx_b1_i), .b2_i(tx_b2_i), .d_i(tx_d_i), .txd_o(txd_o)
  );

  bd_fr_rx #(.POS_W(POS_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fall_i(fall_w), .pos_i(pos_w),
    .lay_i(lay_w), .rxd_i(rxd_i),
    .b1_o(rx_b1_o), .b2_o(rx_b2_o), .d_o(rx_d_o), .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/bd_framer_chk.sv
module bd_framer_chk
  import bd_framer_pkg::*;
#(
  parameter int unsigned POS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_i,
  input logic             bclk_o,
  input logic             fsync_o,
  input logic             txd_o,
  input logic             rx_valid_o,
  input logic             rise_w,
  input logic             fall_w,
  input logic             sync_w,
  input logic [POS_W-1:0] pos_w,
  input logic             lay_w
);
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pos_w) > last_pos(layout_e'(lay_w))) |-> txd_o);

  assert_tx_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rise_w) |-> $stable(txd_o));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_valid_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(fall_w));

  assert_sync_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_w) |-> (pos_w == '0));

  assert_edges_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_w && fall_w));

  assert_slave_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && $past(!master_i)) |-> (!bclk_o && !fsync_o));
endmodule

bind bd_framer bd_framer_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_i(master_i),
  .bclk_o(bclk_o), .fsync_o(fsync_o), .txd_o(txd_o), .rx_valid_o(rx_valid_o),
  .rise_w(rise_w), .fall_w(fall_w), .sync_w(sync_w),
  .pos_w(pos_w), .lay_w(lay_w)
);

// File: tb/bd_framer_test.sv
`timescale 1ns/1ps
module bd_framer_test;
  localparam int DIV  = 4;
  localparam int HALF = 4;
  localparam int NV   = 4;
  // {layout, tx_b1, tx_b2, tx_d, rx_b1, rx_b2, rx_d}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 8'hA5, 8'h3C, 2'b10, 8'h96, 8'h0F, 2'b01},
    {1'b1, 8'h81, 8'h7E, 2'b01, 8'hC3, 8'hF0, 2'b10},
    {1'b0, 8'h00, 8'hFF, 2'b11, 8'hFF, 8'h00, 2'b00},
    {1'b1, 8'h5A, 8'hC0, 2'b00, 8'h01, 8'h80, 2'b11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_i = 1'b0, layout_i = 1'b0, bclk_i = 1'b0, fsync_i = 1'b0;
  logic rx_drv = 1'b0;
  logic [7:0] tx_b1_i = '0, tx_b2_i = '0;
  logic [1:0] tx_d_i = '0;
  logic bclk_o, fsync_o, txd_o, rxd_i, rx_valid_o;
  logic [7:0] rx_b1_o, rx_b2_o;
  logic [1:0] rx_d_o;
  int tests = 0, fails = 0, vcnt = 0;
  logic slave_noise = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign rxd_i = master_i ? txd_o : rx_drv;

  bd_framer #(.CLK_DIV(DIV), .FRAME_BITS(64)) uut (
    .clk(clk), .rst_n(rst_n), .master_i(master_i), .layout_i(layout_i),
    .bclk_i(bclk_i), .fsync_i(fsync_i), .bclk_o(bclk_o), .fsync_o(fsync_o),
    .txd_o(txd_o), .rxd_i(rxd_i), .tx_b1_i(tx_b1_i), .tx_b2_i(tx_b2_i),
    .tx_d_i(tx_d_i), .rx_b1_o(rx_b1_o), .rx_b2_o(rx_b2_o), .rx_d_o(rx_d_o),
    .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) begin
    if (rx_valid_o) vcnt++;
    if (rst_n && !master_i && (bclk_o || fsync_o)) slave_noise = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Frame image, position p at bit 63-p, f fills the unused places
  function automatic logic [63:0] fword(input logic lay, input logic [7:0] b1,
      input logic [7:0] b2, input logic [1:0] d, input logic f);
    if (!lay) return {b1, d[1], f, b2, d[0], {45{f}}};
    return {b1, b2, {8{f}}, d, {38{f}}};
  endfunction

  task automatic bit_cycle(input logic fs, input logic rx, output logic tx);
    bclk_i = 1'b1; fsync_i = fs; rx_drv = rx;
    repeat (HALF) @(negedge clk);
    tx = txd_o;
    bclk_i = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic run_frame(input bit lead, input logic lay,
      input logic [7:0] tb1, input logic [7:0] tb2, input logic [1:0] td,
      input logic [7:0] rb1, input logic [7:0] rb2, input logic [1:0] rd,
      input int stop_at, input int chg_at, output int mism);
    logic [63:0] wexp, r0, r1;
    logic got;
    mism = 0;
    layout_i = lay; tx_b1_i = tb1; tx_b2_i = tb2; tx_d_i = td;
    wexp = fword(lay, tb1, tb2, td, 1'b1);
    r0   = fword(lay, rb1, rb2, rd, 1'b0);
    r1   = fword(lay, rb1, rb2, rd, 1'b1);
    if (lead) bit_cycle(1'b1, 1'b0, got);
    for (int p = 0; p < 64; p++) begin
      if (p == chg_at) begin
        layout_i = ~lay; tx_b1_i = ~tb1; tx_b2_i = ~tb2; tx_d_i = ~td;
      end
      bit_cycle(p == stop_at, p[0] ? r1[63-p] : r0[63-p], got);
      if (got !== wexp[63-p]) mism++;
      if (p == stop_at) break;
    end
  endtask

  initial begin
    int mism, v0, hi, per;
    logic [7:0] sb1, sb2;
    logic [1:0] sd;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(txd_o === 1'b1, "R12", "txd after reset", 64'(txd_o), 64'd1);
    chk(rx_valid_o === 1'b0, "R12", "valid after reset", 64'(rx_valid_o), 64'd0);
    chk({rx_b1_o, rx_b2_o, rx_d_o} === 18'd0, "R12", "rx words after reset",
        64'({rx_b1_o, rx_b2_o, rx_d_o}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3: idle high before any sync, even with bit clock running
    mism = 0;
    for (int i = 0; i < 4; i++) begin
      logic t;
      bit_cycle(1'b0, 1'b0, t);
      if (t !== 1'b1) mism++;
    end
    chk(mism == 0, "R3", "idle before first sync", 64'(mism), 64'd0);

    // Vector table: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      logic [36:0] v;
      v  = VEC[k];
      v0 = vcnt;
      run_frame(1'b1, v[36], v[35:28], v[27:20], v[19:18],
                v[17:10], v[9:2], v[1:0], 64, -1, mism);
      chk(mism == 0, v[36] ? "R2/R3" : "R1/R3", "tx serial mismatches",
          64'(mism), 64'd0);
      chk({rx_b1_o, rx_b2_o, rx_d_o} === {v[17:10], v[9:2], v[1:0]},
          v[36] ? "R5" : "R4", "rx words",
          64'({rx_b1_o, rx_b2_o, rx_d_o}), 64'({v[17:10], v[9:2], v[1:0]}));
      chk(vcnt - v0 == 1, "R6", "valid pulses per frame", 64'(vcnt - v0), 64'd1);
    end

    // R7: early sync at position 10 in the split layout
    sb1 = rx_b1_o; sb2 = rx_b2_o; sd = rx_d_o;
    v0 = vcnt;
    run_frame(1'b1, 1'b0, 8'h11, 8'h22, 2'b01, 8'hEE, 8'hDD, 2'b10, 10, -1, mism);
    chk(vcnt == v0, "R7", "valid on truncated frame", 64'(vcnt - v0), 64'd0);
    chk({rx_b1_o, rx_b2_o, rx_d_o} === {sb1, sb2, sd}, "R7",
        "rx words after truncated frame",
        64'({rx_b1_o, rx_b2_o, rx_d_o}), 64'({sb1, sb2, sd}));
    run_frame(1'b0, 1'b0, 8'h6C, 8'h93, 2'b10, 8'h4B, 8'hB4, 2'b01, 64, -1, mism);
    chk(mism == 0, "R7", "tx restarts at position 0", 64'(mism), 64'd0);
    chk(vcnt - v0 == 1, "R7", "one valid after restart", 64'(vcnt - v0), 64'd1);
    chk({rx_b1_o, rx_b2_o, rx_d_o} === {8'h4B, 8'hB4, 2'b01}, "R7",
        "rx words after restart", 64'({rx_b1_o, rx_b2_o, rx_d_o}),
        64'({8'h4B, 8'hB4, 2'b01}));

    // R8: inputs and layout flip at position 3
    run_frame(1'b1, 1'b1, 8'hE1, 8'h1E, 2'b10, 8'h27, 8'h72, 2'b01, 64, 3, mism);
    chk(mism == 0, "R8", "tx unaffected by mid-frame change", 64'(mism), 64'd0);
    chk({rx_b1_o, rx_b2_o, rx_d_o} === {8'h27, 8'h72, 2'b01}, "R8",
        "rx decoded with captured layout", 64'({rx_b1_o, rx_b2_o, rx_d_o}),
        64'({8'h27, 8'h72, 2'b01}));

    // R11: outputs stayed low throughout slave operation
    chk(slave_noise == 1'b0, "R11", "slave bclk/fsync outputs",
        64'(slave_noise), 64'd0);

    // Master mode: R10 loopback in both layouts
    master_i = 1'b1;
    for (int l = 0; l < 2; l++) begin
      layout_i = l[0];
      tx_b1_i = l[0] ? 8'h6D : 8'hB9;
      tx_b2_i = l[0] ? 8'hB2 : 8'h4E;
      tx_d_i  = l[0] ? 2'b10 : 2'b01;
      repeat (3 * 64 * 2 * DIV) @(negedge clk);
      v0 = vcnt;
      repeat (64 * 2 * DIV) @(negedge clk);
      chk({rx_b1_o, rx_b2_o, rx_d_o} === {tx_b1_i, tx_b2_i, tx_d_i}, "R10",
          l[0] ? "loopback block layout" : "loopback split layout",
          64'({rx_b1_o, rx_b2_o, rx_d_o}), 64'({tx_b1_i, tx_b2_i, tx_d_i}));
      chk(vcnt - v0 == 1, "R10", "one valid per master frame",
          64'(vcnt - v0), 64'd1);
    end

    // R9: generated bit clock and frame sync timing
    while (bclk_o !== 1'b0) @(negedge clk);
    while (bclk_o !== 1'b1) @(negedge clk);
    hi = 0;
    while (bclk_o === 1'b1) begin hi++; @(negedge clk); end
    per = hi;
    while (bclk_o === 1'b0) begin per++; @(negedge clk); end
    chk(hi == DIV, "R9", "bclk high time", 64'(hi), 64'(DIV));
    chk(per == 2 * DIV, "R9", "bclk period", 64'(per), 64'(2 * DIV));
    while (fsync_o !== 1'b0) @(negedge clk);
    while (fsync_o !== 1'b1) @(negedge clk);
    hi = 0;
    while (fsync_o === 1'b1) begin hi++; @(negedge clk); end
    per = hi;
    while (fsync_o === 1'b0) begin per++; @(negedge clk); end
    chk(hi == 32 * 2 * DIV, "R9", "fsync high time", 64'(hi), 64'(32 * 2 * DIV));
    chk(per == 64 * 2 * DIV, "R9", "fsync period", 64'(per), 64'(64 * 2 * DIV));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule